// File: doc/BRIEF.md
# Graphics Coprocessor Host Register Window

This block is the register window through which a host processor controls a 16-bit graphics coprocessor. The host works over a byte-wide bus with a 10-bit offset into a 768-byte window. Through that window it reaches sixteen 16-bit general registers and a 16-bit status word. It also reaches a set of 8-bit control bytes: a backup-RAM enable, three bank selects, a config byte, a screen base, a clock select, a screen mode and a fixed version code. A 16-bit cache base register and a 512-byte cache RAM complete the map. The core datapath and the external memories are not part of the block. The core reports a stop instruction and an interrupt event on two single-cycle strobes.

The block has side-effecting accesses, and these are what set it apart from a plain register file. The run control is a two-state machine, `RUN_IDLE` and `RUN_ACTIVE`. The transition *launch* (IDLE to ACTIVE) fires when the host writes the high byte of the program counter, general register 15. The transition *halt* (ACTIVE to IDLE) fires on the core's stop strobe. The interrupt flag is a second two-state machine, `IRQ_CLEAR` and `IRQ_PENDING`. The transition *raise* fires on the core's interrupt strobe, and the transition *acknowledge* fires when the host reads either byte of the status word. The screen-mode byte hands ROM and cartridge-RAM ownership to the core and selects the frame height and colour depth.

16-bit registers are written low byte first, then high byte. Each byte takes effect on its own write.

Top module: `cop_host_regs`

## Requirements
- R1: After reset every register byte reads 0, except the version byte. `go`, `irq`, `core_owns_rom`, `core_owns_ram`, `fast_mul`, `clk_fast`, `bram_en` and `obj_mode` are 0. `line_count` is 128 and `color_bits` is 2.
- R2: Offsets 0x000–0x01F read back the bytes last written to them. Offset 2n holds the low byte of general register n, and offset 2n+1 holds the high byte. The 8-bit control bytes at 0x033, 0x034, 0x036, 0x037, 0x038, 0x039, 0x03A and 0x03C also read back what was last written to them.
- R3: A write to offset 0x01F takes the run state to `RUN_ACTIVE` from the next cycle. This drives `go` high, and status bit 5 (offset 0x030, bit 5) reads 1. A write to 0x01E does not launch.
- R4: `core_stop` returns the run state to `RUN_IDLE` in the next cycle. If a launch write arrives in the same cycle as `core_stop`, the launch wins.
- R5: `core_irq` sets the interrupt flag, which is status bit 15 (offset 0x031, bit 7). The read that sees the flag returns 1. After a host read of offset 0x030 or 0x031 the flag is 0, unless `core_irq` arrived in the same cycle as that read.
- R6: `irq` is the interrupt flag gated by the inverse of config bit 7 (offset 0x037). `fast_mul` follows config bit 5.
- R7: Offset 0x03E returns written bits 7:4 with bits 3:0 reading 0. Offset 0x03F reads back in full.
- R8: Screen-mode bit 4 (offset 0x03A) drives `core_owns_rom`, and screen-mode bit 3 drives `core_owns_ram`. A value of 1 gives the core ownership and 0 gives the host ownership.
- R9: Screen-mode bits {5,2} select the frame height. 00 gives `line_count` 128, 01 gives 160 and 10 gives 192. 11 sets `obj_mode` with `line_count` 0. Bits {1,0} select `color_bits`: 00 gives 2, 01 gives 4, 11 gives 8 and 10 gives 0.
- R10: Offset 0x03B always reads the `VERSION` parameter, and host writes to it are ignored.
- R11: Offsets 0x100–0x2FF are a 512-byte cache RAM that reads back what was written.
- R12: Offsets 0x020–0x02F, 0x032, 0x035, 0x03D and 0x040–0x0FF, and offsets from 0x300 up, read 0 and ignore writes.
- R13: Host writes to 0x030/0x031 store every status bit except bit 5 and bit 15. Those two bits are unaffected by host writes.
- R14: `clk_fast` follows bit 0 of offset 0x039, and `bram_en` follows bit 0 of offset 0x033.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 10 | Byte offset into the window |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; drives read side effects |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| core_stop | input | 1 | Core executed a stop instruction |
| core_irq | input | 1 | Core raises an interrupt event |
| go | output | 1 | Core is running |
| irq | output | 1 | Unmasked interrupt request to the host |
| core_owns_rom | output | 1 | ROM granted to the core |
| core_owns_ram | output | 1 | Cartridge RAM granted to the core |
| fast_mul | output | 1 | Fast multiplier mode |
| clk_fast | output | 1 | Fast clock select |
| bram_en | output | 1 | Backup RAM enabled |
| obj_mode | output | 1 | Object screen layout selected |
| line_count | output | 9 | Frame height in lines (0 in object mode) |
| color_bits | output | 4 | Bits per pixel (0 for the unused code) |

## Verification
A seeded random mix drives the block. The host side does byte writes and reads over all the map's regions and at arbitrary offsets. The core side fires stop and interrupt strobes in between. Every read and every output is compared against a bench model. This separates correct byte lanes and region decoding from aliasing between regions, and from writes leaking into unused, read-only or masked bits.

Directed cases then drive two pairs of events into the same cycle. A launch write arrives together with a stop, and a status read arrives together with an interrupt, which separates the intended winner from the wrong priority. A sweep over all 64 screen-mode codes separates the height and depth decode from swapped or mis-ordered bits. Writes to 0x01E versus 0x01F show that only the high-byte write launches the core.

// File: rtl/cop_pkg.sv
`timescale 1ns/1ps
package cop_pkg;
    localparam int HOST_AW   = 10;
    localparam int GPR_COUNT = 16;

    localparam logic [3:0] OFS_STAT_LO  = 4'h0;
    localparam logic [3:0] OFS_STAT_HI  = 4'h1;
    localparam logic [3:0] OFS_BRAM     = 4'h3;
    localparam logic [3:0] OFS_PBANK    = 4'h4;
    localparam logic [3:0] OFS_RBANK    = 4'h6;
    localparam logic [3:0] OFS_CFG      = 4'h7;
    localparam logic [3:0] OFS_SBASE    = 4'h8;
    localparam logic [3:0] OFS_CLK      = 4'h9;
    localparam logic [3:0] OFS_SMODE    = 4'hA;
    localparam logic [3:0] OFS_VER      = 4'hB;
    localparam logic [3:0] OFS_WBANK    = 4'hC;
    localparam logic [3:0] OFS_CBASE_LO = 4'hE;
    localparam logic [3:0] OFS_CBASE_HI = 4'hF;

    localparam logic [8:0] LINES_SHORT = 9'd128;
    localparam logic [8:0] LINES_MID   = 9'd160;
    localparam logic [8:0] LINES_TALL  = 9'd192;

    typedef enum logic {RUN_IDLE = 1'b0, RUN_ACTIVE = 1'b1} run_state_e;
    typedef enum logic {IRQ_CLEAR = 1'b0, IRQ_PENDING = 1'b1} irq_state_e;

    typedef struct packed {
        logic [8:0] lines;
        logic       obj_mode;
        logic [3:0] color_bits;
    } screen_cfg_t;

    function automatic screen_cfg_t decode_screen(input logic [7:0] mode);
        screen_cfg_t s;
        s.obj_mode = 1'b0;
        unique case ({mode[5], mode[2]})
            2'b00: s.lines = LINES_SHORT;
            2'b01: s.lines = LINES_MID;
            2'b10: s.lines = LINES_TALL;
            2'b11: begin s.lines = 9'd0; s.obj_mode = 1'b1; end
        endcase
        unique case (mode[1:0])
            2'b00: s.color_bits = 4'd2;
            2'b01: s.color_bits = 4'd4;
            2'b10: s.color_bits = 4'd0;
            2'b11: s.color_bits = 4'd8;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/cop_run_fsm.sv
`timescale 1ns/1ps
module cop_run_fsm
    import cop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic stop,
    output logic go
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE:   if (launch) state_d = RUN_ACTIVE;
            RUN_ACTIVE: if (stop && !launch) state_d = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        go = (state_q == RUN_ACTIVE);
    end

    assert_launch_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> go);
    assert_stop_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !launch) |=> !go);
endmodule

// File: rtl/cop_gpr_file.sv
`timescale 1ns/1ps
module cop_gpr_file #(
    parameter int NREG = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic                     wr_hi,
    input  logic [7:0]               wr_byte,
    input  logic [$clog2(NREG)-1:0]  rd_idx,
    input  logic                     rd_hi,
    output logic [7:0]               rd_byte
);
    localparam int IDX_W = $clog2(NREG);

    logic [15:0] regs_q [NREG];
    logic [15:0] rd_word;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                if (wr_hi) regs_q[g][15:8] <= wr_byte;
                else       regs_q[g][7:0]  <= wr_byte;
            end
        end
    end

    always_comb begin
        rd_word = regs_q[rd_idx];
        rd_byte = rd_hi ? rd_word[15:8] : rd_word[7:0];
    end

    assert_low_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> regs_q[$past(wr_idx)][7:0] == $past(wr_byte));
    assert_high_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> regs_q[$past(wr_idx)][15:8] == $past(wr_byte));
endmodule

// File: rtl/cop_ctrl_regs.sv
`timescale 1ns/1ps
module cop_ctrl_regs
    import cop_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h04
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_status,
    input  logic [3:0]  ofs,
    input  logic [7:0]  wdata,
    input  logic        go,
    input  logic        core_irq,
    output logic [7:0]  rdata,
    output logic        irq_out,
    output logic        fast_mul,
    output logic        clk_fast,
    output logic        bram_en,
    output logic        core_owns_rom,
    output logic        core_owns_ram,
    output screen_cfg_t scr
);
    logic [4:0] stat_lo_q;
    logic [1:0] stat_mid_q;
    logic [6:0] stat_hi_q;
    logic [7:0] bram_q, pbank_q, rbank_q, cfg_q, sbase_q, clk_q, smode_q, wbank_q;
    logic [3:0] cbase_lo_q;
    logic [7:0] cbase_hi_q;
    logic       cfg_wr;

    irq_state_e irq_q, irq_d;

    assign cfg_wr = wr_en && (ofs == OFS_CFG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_lo_q  <= '0;
            stat_mid_q <= '0;
            stat_hi_q  <= '0;
            bram_q     <= '0;
            pbank_q    <= '0;
            rbank_q    <= '0;
            cfg_q      <= '0;
            sbase_q    <= '0;
            clk_q      <= '0;
            smode_q    <= '0;
            wbank_q    <= '0;
            cbase_lo_q <= '0;
            cbase_hi_q <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_STAT_LO: begin
                    stat_lo_q  <= wdata[4:0];
                    stat_mid_q <= wdata[7:6];
                end
                OFS_STAT_HI:  stat_hi_q  <= wdata[6:0];
                OFS_BRAM:     bram_q     <= wdata;
                OFS_PBANK:    pbank_q    <= wdata;
                OFS_RBANK:    rbank_q    <= wdata;
                OFS_CFG:      cfg_q      <= wdata;
                OFS_SBASE:    sbase_q    <= wdata;
                OFS_CLK:      clk_q      <= wdata;
                OFS_SMODE:    smode_q    <= wdata;
                OFS_WBANK:    wbank_q    <= wdata;
                OFS_CBASE_LO: cbase_lo_q <= wdata[7:4];
                OFS_CBASE_HI: cbase_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_CLEAR:   if (core_irq) irq_d = IRQ_PENDING;
            IRQ_PENDING: if (rd_status && !core_irq) irq_d = IRQ_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= IRQ_CLEAR;
        else        irq_q <= irq_d;
    end

    always_comb begin
        case (ofs)
            OFS_STAT_LO:  rdata = {stat_mid_q, go, stat_lo_q};
            OFS_STAT_HI:  rdata = {irq_q == IRQ_PENDING, stat_hi_q};
            OFS_BRAM:     rdata = bram_q;
            OFS_PBANK:    rdata = pbank_q;
            OFS_RBANK:    rdata = rbank_q;
            OFS_CFG:      rdata = cfg_q;
            OFS_SBASE:    rdata = sbase_q;
            OFS_CLK:      rdata = clk_q;
            OFS_SMODE:    rdata = smode_q;
            OFS_VER:      rdata = VERSION;
            OFS_WBANK:    rdata = wbank_q;
            OFS_CBASE_LO: rdata = {cbase_lo_q, 4'h0};
            OFS_CBASE_HI: rdata = cbase_hi_q;
            default:      rdata = 8'h00;
        endcase
    end

    always_comb begin
        irq_out       = (irq_q == IRQ_PENDING) && !cfg_q[7];
        fast_mul      = cfg_q[5];
        clk_fast      = clk_q[0];
        bram_en       = bram_q[0];
        core_owns_rom = smode_q[4];
        core_owns_ram = smode_q[3];
        scr           = decode_screen(smode_q);
    end

    assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |=> (irq_q == IRQ_PENDING));
    assert_irq_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !core_irq) |=> (irq_q == IRQ_CLEAR));
    assert_irq_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq && !cfg_q[7] && !cfg_wr) |=> irq_out);
endmodule

// File: rtl/cop_cache_ram.sv
`timescale 1ns/1ps
module cop_cache_ram #(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/cop_host_regs.sv
`timescale 1ns/1ps
module cop_host_regs
    import cop_pkg::*;
#(
    parameter logic [7:0] VERSION     = 8'h04,
    parameter int         CACHE_BASE  = 256,
    parameter int         CACHE_BYTES = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    input  logic               host_wr,
    input  logic               host_rd,
    output logic [7:0]         host_rdata,
    input  logic               core_stop,
    input  logic               core_irq,
    output logic               go,
    output logic               irq,
    output logic               core_owns_rom,
    output logic               core_owns_ram,
    output logic               fast_mul,
    output logic               clk_fast,
    output logic               bram_en,
    output logic               obj_mode,
    output logic [8:0]         line_count,
    output logic [3:0]         color_bits
);
    localparam int GIDX_W = $clog2(GPR_COUNT);
    localparam int CIDX_W = $clog2(CACHE_BYTES);
    localparam int GPR_SPAN_W = GIDX_W + 1;

    logic gpr_sel, ctrl_sel, cache_sel, launch, status_rd;
    logic [7:0] gpr_rd, ctrl_rd, cache_rd;
    logic [CIDX_W-1:0] cache_idx;
    screen_cfg_t scr;

    always_comb begin
        gpr_sel   = (host_addr[HOST_AW-1:GPR_SPAN_W] == '0);
        ctrl_sel  = (host_addr[HOST_AW-1:4] == (HOST_AW-4)'(3));
        cache_sel = (int'(host_addr) >= CACHE_BASE) &&
                    (int'(host_addr) <  CACHE_BASE + CACHE_BYTES);
        cache_idx = CIDX_W'(host_addr - HOST_AW'(CACHE_BASE));
        launch    = host_wr && (host_addr == HOST_AW'(2 * GPR_COUNT - 1));
        status_rd = host_rd && ctrl_sel && (host_addr[3:1] == 3'b000);
    end

    cop_run_fsm u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .stop   (core_stop),
        .go     (go)
    );

    cop_gpr_file #(.NREG(GPR_COUNT)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr && gpr_sel),
        .wr_idx  (host_addr[GIDX_W:1]),
        .wr_hi   (host_addr[0]),
        .wr_byte (host_wdata),
        .rd_idx  (host_addr[GIDX_W:1]),
        .rd_hi   (host_addr[0]),
        .rd_byte (gpr_rd)
    );

    cop_ctrl_regs #(.VERSION(VERSION)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (host_wr && ctrl_sel),
        .rd_status     (status_rd),
        .ofs           (host_addr[3:0]),
        .wdata         (host_wdata),
        .go            (go),
        .core_irq      (core_irq),
        .rdata         (ctrl_rd),
        .irq_out       (irq),
        .fast_mul      (fast_mul),
        .clk_fast      (clk_fast),
        .bram_en       (bram_en),
        .core_owns_rom (core_owns_rom),
        .core_owns_ram (core_owns_ram),
        .scr           (scr)
    );

    cop_cache_ram #(.DEPTH(CACHE_BYTES)) u_cache (
        .clk   (clk),
        .we    (host_wr && cache_sel),
        .addr  (cache_idx),
        .wdata (host_wdata),
        .rdata (cache_rd)
    );

    always_comb begin
        if (gpr_sel)        host_rdata = gpr_rd;
        else if (ctrl_sel)  host_rdata = ctrl_rd;
        else if (cache_sel) host_rdata = cache_rd;
        else                host_rdata = 8'h00;
        obj_mode   = scr.obj_mode;
        line_count = scr.lines;
        color_bits = scr.color_bits;
    end

    assert_cbase_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == HOST_AW'(12'h03E)) |-> (host_rdata[3:0] == 4'h0));
    assert_version_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == HOST_AW'(12'h03B)) |-> (host_rdata == VERSION));
    assert_gap_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr >= HOST_AW'(12'h040) && host_addr < HOST_AW'(12'h100)) |-> (host_rdata == 8'h00));
endmodule

// File: tb/cop_host_regs_tb_top.sv
`timescale 1ns/1ps
module cop_host_regs_tb_top;
    localparam logic [7:0] VER = 8'h04;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       core_stop = 1'b0, core_irq = 1'b0;
    logic       go, irq, core_owns_rom, core_owns_ram, fast_mul, clk_fast, bram_en, obj_mode;
    logic [8:0] line_count;
    logic [3:0] color_bits;

    always #2 clk = ~clk;

    cop_host_regs #(.VERSION(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .core_stop(core_stop), .core_irq(core_irq), .go(go), .irq(irq),
        .core_owns_rom(core_owns_rom), .core_owns_ram(core_owns_ram),
        .fast_mul(fast_mul), .clk_fast(clk_fast), .bram_en(bram_en),
        .obj_mode(obj_mode), .line_count(line_count), .color_bits(color_bits)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] m_mem [1024];
    bit         m_known [1024];
    bit         m_go = 0, m_irq = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit writable(int a);
        if (a < 32) return 1;
        if (a >= 256 && a < 768) return 1;
        case (a)
            'h30, 'h31, 'h33, 'h34, 'h36, 'h37, 'h38, 'h39, 'h3A, 'h3C, 'h3E, 'h3F: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] model_read(int a);
        if (a == 'h30) return {m_mem[a][7:6], m_go, m_mem[a][4:0]};
        if (a == 'h31) return {m_irq, m_mem[a][6:0]};
        if (a == 'h3B) return VER;
        if (a == 'h3E) return {m_mem[a][7:4], 4'h0};
        if (writable(a)) return m_mem[a];
        return 8'h00;
    endfunction

    function automatic int exp_lines(logic [7:0] m);
        case ({m[5], m[2]})
            2'b00: return 128;
            2'b01: return 160;
            2'b10: return 192;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_color(logic [7:0] m);
        case (m[1:0])
            2'b00: return 2;
            2'b01: return 4;
            2'b11: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic check_outputs(string tag);
        logic [7:0] sm;
        sm = m_mem['h3A];
        chk("R3", {tag, " go"}, int'(go), int'(m_go));
        chk("R6", {tag, " irq"}, int'(irq), int'(m_irq && !m_mem['h37][7]));
        chk("R6", {tag, " fast_mul"}, int'(fast_mul), int'(m_mem['h37][5]));
        chk("R8", {tag, " rom owner"}, int'(core_owns_rom), int'(sm[4]));
        chk("R8", {tag, " ram owner"}, int'(core_owns_ram), int'(sm[3]));
        chk("R9", {tag, " lines"}, int'(line_count), exp_lines(sm));
        chk("R9", {tag, " obj"}, int'(obj_mode), int'(sm[5] && sm[2]));
        chk("R9", {tag, " color"}, int'(color_bits), exp_color(sm));
        chk("R14", {tag, " clk_fast"}, int'(clk_fast), int'(m_mem['h39][0]));
        chk("R14", {tag, " bram_en"}, int'(bram_en), int'(m_mem['h33][0]));
    endtask

    task automatic host_write(int a, logic [7:0] d);
        @(negedge clk);
        host_addr = 10'(a); host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        if (writable(a)) begin m_mem[a] = d; m_known[a] = 1; end
        if (a == 'h1F) m_go = 1;
    endtask

    task automatic host_read(int a, string req);
        logic [7:0] v;
        @(negedge clk);
        host_addr = 10'(a); host_rd = 1'b1;
        #1 v = host_rdata;
        if (m_known[a]) chk(req, $sformatf("read %03h", a), int'(v), int'(model_read(a)));
        @(negedge clk);
        host_rd = 1'b0;
        if (a == 'h30 || a == 'h31) m_irq = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); core_stop = 1'b1;
        @(negedge clk); core_stop = 1'b0;
        m_go = 0;
    endtask

    task automatic pulse_irq();
        @(negedge clk); core_irq = 1'b1;
        @(negedge clk); core_irq = 1'b0;
        m_irq = 1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int a, kind;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin
            m_mem[i] = 8'h00;
            m_known[i] = !(i >= 256 && i < 768);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_outputs("R1 reset");
        host_read('h00, "R1"); host_read('h1F, "R1"); host_read('h30, "R1");
        host_read('h31, "R1"); host_read('h3A, "R1"); host_read('h3E, "R1");
        host_read('h3B, "R10");

        // R3: low byte of PC does not launch, high byte does
        host_write('h1E, 8'h34);
        chk("R3", "no launch on low byte", int'(go), 0);
        host_write('h1F, 8'h12);
        chk("R3", "launch on high byte", int'(go), 1);
        host_read('h30, "R3");
        host_read('h1E, "R2"); host_read('h1F, "R2");

        // R4: stop clears, simultaneous launch wins
        pulse_stop();
        chk("R4", "stop clears go", int'(go), 0);
        @(negedge clk);
        host_addr = 10'h01F; host_wdata = 8'h55; host_wr = 1'b1; core_stop = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; core_stop = 1'b0; m_mem['h1F] = 8'h55; m_go = 1;
        chk("R4", "launch beats stop", int'(go), 1);
        pulse_stop();

        // R5/R6: interrupt flag, acknowledge, mask
        pulse_irq();
        chk("R5", "irq raised", int'(irq), 1);
        host_read('h31, "R5");
        chk("R5", "irq acknowledged", int'(irq), 0);
        pulse_irq();
        @(negedge clk);
        host_addr = 10'h030; host_rd = 1'b1; core_irq = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; core_irq = 1'b0;
        chk("R5", "raise beats acknowledge", int'(irq), 1);
        host_write('h37, 8'hA0);
        chk("R6", "masked irq", int'(irq), 0);
        chk("R6", "fast_mul on", int'(fast_mul), 1);
        host_write('h37, 8'h00);
        chk("R6", "unmasked irq", int'(irq), 1);
        host_read('h30, "R5");
        chk("R5", "cleared after status low read", int'(irq), 0);

        // R13: status bits 5 and 15 not host-writable
        host_write('h30, 8'hFF); host_write('h31, 8'hFF);
        host_read('h30, "R13"); host_read('h31, "R13");

        // R7, R10, R12
        host_write('h3E, 8'hAB); host_read('h3E, "R7");
        host_write('h3F, 8'hCD); host_read('h3F, "R7");
        host_write('h3B, 8'h99); host_read('h3B, "R10");
        host_write('h25, 8'h77); host_read('h25, "R12");
        host_write('h35, 8'h77); host_read('h35, "R12");
        host_write('h80, 8'h77); host_read('h80, "R12");
        host_write('h300, 8'h77); host_read('h300, "R12");
        host_read('h3D, "R12");

        // R11: cache boundaries
        host_write('h100, 8'h5A); host_write('h2FF, 8'hA5);
        host_read('h100, "R11"); host_read('h2FF, "R11");

        // R8/R9: all screen-mode codes
        for (int m = 0; m < 64; m++) begin
            host_write('h3A, 8'(m));
            check_outputs("R9 sweep");
        end

        // Random mix over the whole map
        for (int i = 0; i < 3000; i++) begin
            kind = int'($urandom % 12);
            case ($urandom % 4)
                0: a = int'($urandom % 32);
                1: a = 'h30 + int'($urandom % 16);
                2: a = 256 + int'($urandom % 512);
                default: a = int'($urandom % 1024);
            endcase
            if (kind < 6)       host_write(a, 8'($urandom));
            else if (kind < 10) host_read(a, "R2");
            else if (kind == 10) pulse_stop();
            else                 pulse_irq();
            if (i % 50 == 0) check_outputs("random");
        end
        check_outputs("final");
        finish_run();
    end
endmodule